// File: doc/BRIEF.md
# Delayed-Branch Program Sequencer

This block produces the fetch address for a four-stage instruction pipeline made of fetch, decode, operand read and execute stages. Every control decision is taken when an instruction sits in the execute stage. At that point the three younger instructions already occupy read, decode and fetch. A standard branch discards those three and pays four cycles. A delayed branch, and the delayed decrement-and-branch on an auxiliary register, let all three run as delay slots, so the redirect costs a single cycle.

The sequencer also runs a zero-overhead block repeat. A repeat-setup instruction loads a start address, an end address and a remaining count. Each fetch of the end address while the count is nonzero goes back to the start and lowers the count by one. A loaded count of N therefore runs the block N+1 times. A stall input freezes the whole sequencer. A control instruction found in the delay slots of an accepted delayed instruction is refused and an error flag is raised.

The surrounding core decodes each instruction. For the instruction currently in the execute stage it supplies the kind code, the target, the condition result, the auxiliary register value and the repeat setup values. It writes back the decremented register value when told to do so.

Top module: `dbseq_top`

## Requirements
- R1: While reset is high, fetch_addr is RESET_ADDR (0), stg_valid is 4'b0001 (bit 0 fetch, bit 3 execute), rpt_cnt_q is 0 and squash is 0.
- R2: With no redirect, no repeat wrap and no stall, fetch_addr rises by one every cycle. An instruction fetched in cycle k shows in execute (stg_valid[3]=1, exe_addr equal to its address) in cycle k+3.
- R3: A standard branch (br_kind 1) in execute drives squash to 3'b111 in that same cycle (bit 0 fetch, bit 1 decode, bit 2 read). The three younger instructions never reach execute. The next fetch is br_target when cond_ok is 1, else the branch address plus one. The next instruction executes four cycles after the branch.
- R4: A delayed branch (br_kind 2) in execute raises no squash. When cond_ok is 1 the next fetch is br_target. The three following instructions execute back to back, and the target executes in the cycle right after them.
- R5: A delayed decrement-and-branch (br_kind 3) in execute always pulses ar_wr_en with ar_wr_data = ar_value - 1. It redirects to br_target only when cond_ok is 1 and the decremented value is nonzero. Its three followers execute as for R4.
- R6: A repeat setup (br_kind 4) in execute loads rpt_start_in, rpt_end_in and rpt_cnt_in. They appear on rpt_start_q, rpt_end_q and rpt_cnt_q in the next cycle.
- R7: When fetch_addr equals rpt_end_q and rpt_cnt_q is nonzero, the next fetch is rpt_start_q and the count drops by one. With a count of 0, fetch falls through. A redirect from execute in the same cycle takes priority and leaves the count unchanged.
- R8: While stall is high, fetch_addr, stg_valid and the repeat registers hold. The execute-stage inputs are ignored, with no ar_wr_en, squash or redirect.
- R9: A nonzero br_kind in any of the three valid instructions that execute after an accepted br_kind 2 or 3 is refused. slot_err is high for that cycle, and the instruction causes no redirect, squash, register write or repeat load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Freeze all stages and state |
| br_kind | input | 3 | Kind code of the execute-stage instruction: 0 none, 1 standard, 2 delayed, 3 delayed decrement-and-branch, 4 repeat setup |
| cond_ok | input | 1 | Condition result for the execute-stage instruction |
| br_target | input | ADDR_W | Branch target |
| ar_value | input | AR_W | Current value of the named auxiliary register |
| rpt_start_in | input | ADDR_W | Repeat block first address to load |
| rpt_end_in | input | ADDR_W | Repeat block last address to load |
| rpt_cnt_in | input | CNT_W | Repeat count to load |
| fetch_addr | output | ADDR_W | Address fetched this cycle |
| exe_addr | output | ADDR_W | Address of the instruction in execute |
| stg_valid | output | STAGES | Valid bit per stage, bit 0 fetch to bit 3 execute |
| squash | output | STAGES-1 | Kill fetch, decode and read instructions this cycle |
| ar_wr_en | output | 1 | Write decremented register value |
| ar_wr_data | output | AR_W | Decremented register value |
| rpt_start_q | output | ADDR_W | Repeat start register |
| rpt_end_q | output | ADDR_W | Repeat end register |
| rpt_cnt_q | output | CNT_W | Repeat remaining count |
| slot_err | output | 1 | Control instruction refused in a delay slot |

## Verification
The assertions check on every cycle a set of local rules. A squash empties the younger stages, and a stall holds the fetch address, the valid bits and the count. An accepted delayed branch lands on its target. The count never moves by more than one except on a load, and a refused slot instruction touches nothing. The full ordering of executed addresses can only be shown by the bench's scenarios. This covers the four-cycle penalty, the unbroken run of delay slots, the number of passes made by a decrement loop or a repeat block, and the priority of a redirect over a repeat wrap. The bench compares that ordering, cycle by cycle, against streams it builds by arithmetic, with and without a periodic stall.

// File: rtl/dbseq_pkg.sv
package dbseq_pkg;

    typedef enum logic [2:0] {
        K_NONE = 3'd0,
        K_STD  = 3'd1,
        K_DLY  = 3'd2,
        K_DBNZ = 3'd3,
        K_RPT  = 3'd4
    } kind_e;

endpackage

// File: rtl/dbseq_resolve.sv
module dbseq_resolve
    import dbseq_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int AR_W      = 24,
    parameter int SLOT_W    = 2,
    parameter int SLOT_FULL = 3
) (
    input  logic              ex_go,
    input  logic [2:0]        kind,
    input  logic              cond_ok,
    input  logic [ADDR_W-1:0] target,
    input  logic [ADDR_W-1:0] ex_addr,
    input  logic [AR_W-1:0]   ar_value,
    input  logic [SLOT_W-1:0] slot_cnt,
    output logic              redirect,
    output logic [ADDR_W-1:0] redir_addr,
    output logic              kill,
    output logic              ar_we,
    output logic [AR_W-1:0]   ar_wd,
    output logic              rpt_load,
    output logic              slot_err,
    output logic [SLOT_W-1:0] slot_next
);
    localparam logic [ADDR_W-1:0] ONE_A  = ADDR_W'(1);
    localparam logic [AR_W-1:0]   ONE_R  = AR_W'(1);
    localparam logic [SLOT_W-1:0] ONE_S  = SLOT_W'(1);
    localparam logic [SLOT_W-1:0] FULL_S = SLOT_W'(SLOT_FULL);

    logic in_slot;
    logic accept;
    logic arm;

    always_comb begin
        in_slot    = (slot_cnt != '0);
        slot_err   = ex_go && in_slot && (kind != K_NONE);
        accept     = ex_go && !slot_err;
        arm        = 1'b0;
        redirect   = 1'b0;
        redir_addr = target;
        kill       = 1'b0;
        ar_we      = 1'b0;
        ar_wd      = ar_value - ONE_R;
        rpt_load   = 1'b0;
        case (kind)
            K_STD: begin
                redirect   = accept;
                kill       = accept;
                redir_addr = cond_ok ? target : ex_addr + ONE_A;
            end
            K_DLY: begin
                redirect = accept && cond_ok;
                arm      = accept;
            end
            K_DBNZ: begin
                ar_we    = accept;
                redirect = accept && cond_ok && (ar_wd != '0);
                arm      = accept;
            end
            K_RPT: begin
                rpt_load = accept;
            end
            default: begin
            end
        endcase
        if (!ex_go) begin
            slot_next = slot_cnt;
        end else if (arm) begin
            slot_next = FULL_S;
        end else if (in_slot) begin
            slot_next = slot_cnt - ONE_S;
        end else begin
            slot_next = slot_cnt;
        end
    end

endmodule

// File: rtl/dbseq_pipe.sv
module dbseq_pipe #(
    parameter int STAGES = 4,
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    input  logic              kill,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic [STAGES-1:0] valid,
    output logic [ADDR_W-1:0] last_addr
);
    localparam logic [STAGES-1:0] V_RESET = STAGES'(1);

    logic [STAGES-1:0] v_d, v_q;
    logic [ADDR_W-1:0] a_d [1:STAGES-1];
    logic [ADDR_W-1:0] a_q [1:STAGES-1];

    always_comb begin
        v_d    = v_q;
        v_d[0] = 1'b1;
        if (adv) begin
            for (int i = 1; i < STAGES; i++) begin
                v_d[i] = v_q[i-1] && !kill;
            end
        end
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_addr
        if (g == 1) begin : g_first
            always_comb a_d[g] = adv ? fetch_addr : a_q[g];
        end else begin : g_rest
            always_comb a_d[g] = adv ? a_q[g-1] : a_q[g];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q <= V_RESET;
            for (int i = 1; i < STAGES; i++) a_q[i] <= '0;
        end else begin
            v_q <= v_d;
            for (int i = 1; i < STAGES; i++) a_q[i] <= a_d[i];
        end
    end

    assign valid     = v_q;
    assign last_addr = a_q[STAGES-1];

    // R3
    kill_empties_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && kill) |=> (valid[STAGES-1:1] == '0));

endmodule

// File: rtl/dbseq_rpt.sv
module dbseq_rpt #(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    input  logic              load,
    input  logic [ADDR_W-1:0] ld_start,
    input  logic [ADDR_W-1:0] ld_end,
    input  logic [CNT_W-1:0]  ld_cnt,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              redirect,
    output logic              wrap,
    output logic [ADDR_W-1:0] rs,
    output logic [ADDR_W-1:0] re,
    output logic [CNT_W-1:0]  rc
);
    localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

    typedef struct packed {
        logic [ADDR_W-1:0] rs;
        logic [ADDR_W-1:0] re;
        logic [CNT_W-1:0]  rc;
    } rpt_t;

    rpt_t r_d, r_q;

    always_comb begin
        wrap = (fetch_addr == r_q.re) && (r_q.rc != '0);
        r_d  = r_q;
        if (adv) begin
            if (load) begin
                r_d.rs = ld_start;
                r_d.re = ld_end;
                r_d.rc = ld_cnt;
            end else if (wrap && !redirect) begin
                r_d.rc = r_q.rc - ONE_C;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign rs = r_q.rs;
    assign re = r_q.re;
    assign rc = r_q.rc;

    // R7
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> ((rc == $past(rc)) || (rc == $past(rc) - ONE_C)));

    // R7
    wrap_dec_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && wrap && !redirect && !load) |=> (rc == $past(rc) - ONE_C));

    // R7
    redirect_keeps_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        (redirect && !load) |=> (rc == $past(rc)));

endmodule

// File: rtl/dbseq_top.sv
module dbseq_top
    import dbseq_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int AR_W   = 24,
    parameter int CNT_W  = 24,
    parameter int STAGES = 4,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stall,
    input  logic [2:0]        br_kind,
    input  logic              cond_ok,
    input  logic [ADDR_W-1:0] br_target,
    input  logic [AR_W-1:0]   ar_value,
    input  logic [ADDR_W-1:0] rpt_start_in,
    input  logic [ADDR_W-1:0] rpt_end_in,
    input  logic [CNT_W-1:0]  rpt_cnt_in,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic [ADDR_W-1:0] exe_addr,
    output logic [STAGES-1:0] stg_valid,
    output logic [STAGES-2:0] squash,
    output logic              ar_wr_en,
    output logic [AR_W-1:0]   ar_wr_data,
    output logic [ADDR_W-1:0] rpt_start_q,
    output logic [ADDR_W-1:0] rpt_end_q,
    output logic [CNT_W-1:0]  rpt_cnt_q,
    output logic              slot_err
);
    localparam int SLOTS  = STAGES - 1;
    localparam int SLOT_W = $clog2(STAGES);
    localparam logic [ADDR_W-1:0] ONE_A = ADDR_W'(1);

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [SLOT_W-1:0] slot;
    } seq_t;

    seq_t s_d, s_q;

    logic              adv;
    logic              ex_go;
    logic              redirect;
    logic [ADDR_W-1:0] redir_addr;
    logic              kill;
    logic              rpt_load;
    logic              wrap;
    logic [SLOT_W-1:0] slot_next;

    assign adv   = !stall;
    assign ex_go = adv && stg_valid[STAGES-1];

    dbseq_resolve #(
        .ADDR_W(ADDR_W), .AR_W(AR_W), .SLOT_W(SLOT_W), .SLOT_FULL(SLOTS)
    ) resolve_i (
        .ex_go(ex_go), .kind(br_kind), .cond_ok(cond_ok), .target(br_target),
        .ex_addr(exe_addr), .ar_value(ar_value), .slot_cnt(s_q.slot),
        .redirect(redirect), .redir_addr(redir_addr), .kill(kill),
        .ar_we(ar_wr_en), .ar_wd(ar_wr_data), .rpt_load(rpt_load),
        .slot_err(slot_err), .slot_next(slot_next)
    );

    dbseq_pipe #(.STAGES(STAGES), .ADDR_W(ADDR_W)) pipe_i (
        .clk(clk), .rst(rst), .adv(adv), .kill(kill), .fetch_addr(s_q.pc),
        .valid(stg_valid), .last_addr(exe_addr)
    );

    dbseq_rpt #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) rpt_i (
        .clk(clk), .rst(rst), .adv(adv), .load(rpt_load),
        .ld_start(rpt_start_in), .ld_end(rpt_end_in), .ld_cnt(rpt_cnt_in),
        .fetch_addr(s_q.pc), .redirect(redirect), .wrap(wrap),
        .rs(rpt_start_q), .re(rpt_end_q), .rc(rpt_cnt_q)
    );

    always_comb begin
        s_d = s_q;
        if (adv) begin
            if (redirect)  s_d.pc = redir_addr;
            else if (wrap) s_d.pc = rpt_start_q;
            else           s_d.pc = s_q.pc + ONE_A;
            s_d.slot = slot_next;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.pc   <= RESET_ADDR;
            s_q.slot <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign fetch_addr = s_q.pc;
    assign squash     = {SLOTS{kill}};

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        stall |=> ($stable(fetch_addr) && $stable(stg_valid) && $stable(rpt_cnt_q)));

    // R8
    stall_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        stall |-> (!ar_wr_en && (squash == '0) && !slot_err));

    // R2
    seq_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!stall && !redirect && !wrap) |=> (fetch_addr == $past(fetch_addr) + ONE_A));

    // R4
    dly_land_chk: assert property (@(posedge clk) disable iff (rst)
        (ex_go && (br_kind == K_DLY) && cond_ok && !slot_err) |=> (fetch_addr == $past(br_target)));

    // R9
    slot_reject_chk: assert property (@(posedge clk) disable iff (rst)
        slot_err |-> (!redirect && !ar_wr_en && (squash == '0) && !rpt_load));

endmodule

// File: tb/dbseq_top_tb_top.sv
module dbseq_top_tb_top;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst, stall, cond_ok;
    logic [2:0]  br_kind;
    logic [23:0] br_target, ar_value, rpt_start_in, rpt_end_in, rpt_cnt_in;
    logic [23:0] fetch_addr, exe_addr, ar_wr_data, rpt_start_q, rpt_end_q, rpt_cnt_q;
    logic [3:0]  stg_valid;
    logic [2:0]  squash;
    logic        ar_wr_en, slot_err;

    dbseq_top dut_i (
        .clk(clk), .rst(rst), .stall(stall), .br_kind(br_kind), .cond_ok(cond_ok),
        .br_target(br_target), .ar_value(ar_value), .rpt_start_in(rpt_start_in),
        .rpt_end_in(rpt_end_in), .rpt_cnt_in(rpt_cnt_in), .fetch_addr(fetch_addr),
        .exe_addr(exe_addr), .stg_valid(stg_valid), .squash(squash),
        .ar_wr_en(ar_wr_en), .ar_wr_data(ar_wr_data), .rpt_start_q(rpt_start_q),
        .rpt_end_q(rpt_end_q), .rpt_cnt_q(rpt_cnt_q), .slot_err(slot_err)
    );

    int checks = 0;
    int fails  = 0;
    int pk [64];
    int pt [64];
    int pcnd [64];
    int pe [64];
    int pn [64];
    int got [128];
    int expv [128];
    int ngot, ne;
    int ar_model, err_cnt, ar_wr_cnt, sq_cnt;
    int cyc = 0;

    initial begin
        while (cyc < 200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    always @(posedge clk) cyc++;

    task automatic chk(input bit ok, input string tag, input int act, input int ex);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, ex);
        end
    endtask

    task automatic idle_in();
        br_kind = 3'd0; cond_ok = 1'b0; br_target = '0;
        rpt_start_in = '0; rpt_end_in = '0; rpt_cnt_in = '0;
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 64; i++) begin
            pk[i] = 0; pt[i] = 0; pcnd[i] = 1; pe[i] = 0; pn[i] = 0;
        end
        ne = 0;
    endtask

    task automatic push(input int v);
        if (ne < 128) begin expv[ne] = v; ne++; end
    endtask

    task automatic push_seq(input int from, input int upto);
        for (int i = from; i <= upto; i++) push(i);
    endtask

    task automatic push_tail(input int from, input int n);
        int v;
        v = from;
        while (ne < n) begin push(v); v++; end
    endtask

    task automatic do_reset(input int ar0);
        rst = 1'b1; stall = 1'b0; idle_in();
        ar_model = ar0; ar_value = 24'(ar0);
        @(negedge clk); @(negedge clk);
        // R1
        chk(fetch_addr == 24'd0, "R1 fetch_addr", int'(fetch_addr), 0);
        chk(stg_valid == 4'b0001, "R1 stg_valid", int'(stg_valid), 1);
        chk(rpt_cnt_q == 24'd0, "R1 rpt_cnt_q", int'(rpt_cnt_q), 0);
        chk(squash == 3'd0, "R1 squash", int'(squash), 0);
        rst = 1'b0;
    endtask

    task automatic run_prog(input int n, input int smode);
        int guard, idx;
        logic st;
        logic [23:0] pf;
        ngot = 0; err_cnt = 0; ar_wr_cnt = 0; sq_cnt = 0; guard = 0;
        while (ngot < n && guard < 3000) begin
            st = (smode != 0) && ((guard % 3) == 1);
            stall = st;
            idx = int'(exe_addr[5:0]);
            ar_value = 24'(ar_model);
            if (stg_valid[3] && !st) begin
                br_kind = 3'(pk[idx]); cond_ok = (pcnd[idx] != 0);
                br_target = 24'(pt[idx]); rpt_start_in = 24'(pt[idx]);
                rpt_end_in = 24'(pe[idx]); rpt_cnt_in = 24'(pn[idx]);
            end else begin
                idle_in();
            end
            #1;
            if (slot_err) err_cnt++;
            if (|squash) sq_cnt++;
            if (ar_wr_en) begin ar_wr_cnt++; ar_model = int'(ar_wr_data); end
            if (!st) begin
                got[ngot] = stg_valid[3] ? int'(exe_addr) : -1;
                ngot++;
            end
            pf = fetch_addr;
            @(negedge clk);
            guard++;
            // R8
            if (st) chk(fetch_addr == pf, "R8 fetch held in stall", int'(fetch_addr), int'(pf));
        end
        stall = 1'b0; idle_in();
        chk(ngot >= n, "run progress", ngot, n);
    endtask

    task automatic compare(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            checks++;
            if (got[i] != expv[i]) begin
                fails++;
                $display("FAIL %s slot %0d: actual %0d expected %0d", tag, i, got[i], expv[i]);
            end
        end
    endtask

    localparam int N = 40;

    initial begin
        rst = 1'b1; stall = 1'b0; idle_in(); ar_value = '0;

        // R2: plain sequential stream
        for (int sm = 0; sm < 2; sm++) begin
            clear_prog(); do_reset(0);
            push(-1); push(-1); push(-1); push_tail(0, N);
            run_prog(N, sm);
            compare(N, "R2 sequential");
        end

        // R4: delayed branch sweep, with and without stall
        for (int sm = 0; sm < 2; sm++)
            for (int a = 2; a <= 5; a += 3)
                for (int t = 20; t <= 33; t += 13) begin
                    clear_prog(); pk[a] = 2; pt[a] = t; pcnd[a] = 1;
                    do_reset(0);
                    push(-1); push(-1); push(-1); push_seq(0, a + 3); push_tail(t, N);
                    run_prog(N, sm);
                    compare(N, "R4 delayed taken");
                    chk(sq_cnt == 0, "R4 no squash", sq_cnt, 0);
                end

        // R4: delayed branch with false condition
        clear_prog(); pk[3] = 2; pt[3] = 30; pcnd[3] = 0; do_reset(0);
        push(-1); push(-1); push(-1); push_tail(0, N);
        run_prog(N, 0);
        compare(N, "R4 delayed not taken");

        // R3: standard branch, taken and not taken
        for (int a = 2; a <= 4; a += 2)
            for (int tk = 0; tk < 2; tk++) begin
                clear_prog(); pk[a] = 1; pt[a] = 25; pcnd[a] = tk; do_reset(0);
                push(-1); push(-1); push(-1); push_seq(0, a);
                push(-1); push(-1); push(-1);
                push_tail((tk != 0) ? 25 : a + 1, N);
                run_prog(N, 0);
                compare(N, "R3 standard branch");
                chk(sq_cnt == 1, "R3 squash pulses", sq_cnt, 1);
            end

        // R5: decrement loop, body 3..6, branch at 6, slots 7..9
        for (int sm = 0; sm < 2; sm++)
            for (int it = 1; it <= 4; it++) begin
                if (it == 3) continue;
                clear_prog(); pk[6] = 3; pt[6] = 3; pcnd[6] = 1; do_reset(it);
                push(-1); push(-1); push(-1); push_seq(0, 9);
                for (int p = 2; p <= it; p++) push_seq(3, 9);
                push_tail(10, N);
                run_prog(N, sm);
                compare(N, "R5 decrement loop");
                chk(ar_wr_cnt == it, "R5 register writes", ar_wr_cnt, it);
                chk(ar_model == 0, "R5 final register", ar_model, 0);
            end

        // R5: false condition still decrements, no redirect
        clear_prog(); pk[6] = 3; pt[6] = 3; pcnd[6] = 0; do_reset(5);
        push(-1); push(-1); push(-1); push_tail(0, N);
        run_prog(N, 0);
        compare(N, "R5 decrement no branch");
        chk(ar_model == 4, "R5 decrement once", ar_model, 4);

        // R6 R7: repeat blocks loaded at address 1
        for (int sm = 0; sm < 2; sm++)
            for (int c = 0; c < 4; c++) begin
                int s, e, cn;
                s  = (c == 3) ? 7 : 6;
                e  = (c == 3) ? 7 : 8;
                cn = (c == 3) ? 2 : ((c == 2) ? 3 : c);
                clear_prog(); pk[1] = 4; pt[1] = s; pe[1] = e; pn[1] = cn; do_reset(0);
                push(-1); push(-1); push(-1); push_seq(0, e);
                for (int p = 0; p < cn; p++) push_seq(s, e);
                push_tail(e + 1, N);
                run_prog(N, sm);
                compare(N, "R7 repeat stream");
                chk(rpt_cnt_q == 24'd0, "R7 count exhausted", int'(rpt_cnt_q), 0);
                chk(rpt_start_q == 24'(s), "R6 start loaded", int'(rpt_start_q), s);
                chk(rpt_end_q == 24'(e), "R6 end loaded", int'(rpt_end_q), e);
            end

        // R7: redirect beats wrap on the block end
        clear_prog(); pk[0] = 4; pt[0] = 5; pe[0] = 8; pn[0] = 2;
        pk[5] = 2; pt[5] = 30; pcnd[5] = 1; do_reset(0);
        push(-1); push(-1); push(-1); push_seq(0, 8); push_tail(30, N);
        run_prog(N, 0);
        compare(N, "R7 redirect priority");
        chk(rpt_cnt_q == 24'd2, "R7 count kept", int'(rpt_cnt_q), 2);

        // R9: control instructions inside delay slots are refused
        for (int v = 0; v < 3; v++) begin
            int sa;
            clear_prog(); pk[2] = 2; pt[2] = 20; pcnd[2] = 1;
            sa = 3 + v;
            pk[sa] = (v == 0) ? 1 : ((v == 1) ? 2 : 3);
            pt[sa] = 40; pcnd[sa] = 1;
            do_reset(7);
            push(-1); push(-1); push(-1); push_seq(0, 5); push_tail(20, N);
            run_prog(N, 0);
            compare(N, "R9 first branch wins");
            chk(err_cnt == 1, "R9 slot_err count", err_cnt, 1);
            chk(sq_cnt == 0, "R9 no squash", sq_cnt, 0);
            chk(ar_wr_cnt == 0, "R9 no register write", ar_wr_cnt, 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule